// File: doc/BRIEF.md
# Bit-Serial Pipelined Maximum/Minimum Finder

This block returns the largest or the smallest of a set of unsigned operands that arrive together in one cycle. It does not use a tree of comparators. A chain of bit-slice stages examines one bit position each, from the most significant bit down. Every operand carries a candidate flag. At each stage the candidates that cannot be the extreme value lose their flag, and the stage emits one bit of the result.

A complete operand set enters on any cycle in which `valid_i` is high. A register sits after every stage, so a new set can be accepted on every clock. The result word, together with a mask of the operands that equal it, appears exactly `WIDTH` cycles later. For a minimum, the operands are inverted on entry and the result is inverted on exit. The stages themselves only ever search for a maximum, which keeps the per-bit logic small. Each operand set carries its own mode bit through the pipeline.

Top module: `minmax_tracker`

## Requirements
- R1: An operand set sampled with `valid_i` high on a clock edge produces `valid_o` high after exactly `WIDTH` rising edges, counting the sampling edge as the first. Sets given on consecutive cycles come out on consecutive cycles in the same order.
- R2: With `mode_i` = 0 for that set, `res_o` equals the largest unsigned operand, where operand i is `ops_i[i*WIDTH +: WIDTH]`.
- R3: With `mode_i` = 1 for that set, `res_o` equals the smallest unsigned operand.
- R4: Together with each result, bit i of `cand_o` is 1 exactly when operand i equals `res_o`. With tied operands, several bits are set, and at least one bit is always set.
- R5: The mode is captured along with each operand set. Changing `mode_i` on every cycle gives every set its own operation, with no effect on sets already in flight.
- R6: A cycle with `valid_i` low produces no output, whatever `ops_i` and `mode_i` hold. While `valid_o` is low, `res_o` and `cand_o` are zero.
- R7: While `rst_ni` is low, `valid_o`, `res_o` and `cand_o` are zero.
- R8: When all operands are equal, including all zeros and all ones, `res_o` equals that value in both modes and every bit of `cand_o` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand set present this cycle |
| mode_i | input | 1 | 0 selects maximum, 1 selects minimum |
| ops_i | input | N_OPS*WIDTH | Operands, operand i in bits i*WIDTH +: WIDTH |
| valid_o | output | 1 | Result present this cycle |
| res_o | output | WIDTH | Extreme value of the set |
| cand_o | output | N_OPS | Operands equal to the extreme value |

## Verification
Each stage writes its result bit once and never revisits it. A wrong candidate flag in one stage therefore corrupts only the lower bits of that set's `res_o` and leaves a `cand_o` mask that disagrees with the operand values. Both effects show at the ports `WIDTH` cycles after the set entered. A skewed valid or mode register shows up as an output arriving in the wrong cycle, as a result paired with the neighbouring set, or as a maximum returned where a minimum was requested. Back-to-back sets with alternating modes and deliberate ties expose these faults at the first affected output.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;
  typedef enum logic {
    MODE_MAX = 1'b0,
    MODE_MIN = 1'b1
  } mode_e;
endpackage

// File: rtl/mmt_cond.sv
`timescale 1ns/1ps
// Conditional bitwise inversion of a group of words (min-to-max mapping).
module mmt_cond #(
  parameter int unsigned N_OPS = 9,
  parameter int unsigned WIDTH = 8
) (
  input  logic [N_OPS-1:0][WIDTH-1:0] ops_i,
  input  logic                        invert_i,
  output logic [N_OPS-1:0][WIDTH-1:0] ops_o
);
  for (genvar i = 0; i < N_OPS; i++) begin : g_word
    assign ops_o[i] = ops_i[i] ^ {WIDTH{invert_i}};
  end
endmodule

// File: rtl/mmt_bit_pe.sv
`timescale 1ns/1ps
// One bit slice of the max search: keeps candidates holding a 1 if any exist.
module mmt_bit_pe #(
  parameter int unsigned N_OPS = 9
) (
  input  logic [N_OPS-1:0] bits_i,
  input  logic [N_OPS-1:0] flags_i,
  output logic             hit_o,
  output logic [N_OPS-1:0] flags_o
);
  logic [N_OPS-1:0] live;

  assign live    = bits_i & flags_i;
  assign hit_o   = |live;
  assign flags_o = hit_o ? live : flags_i;
endmodule

// File: rtl/mmt_stage.sv
`timescale 1ns/1ps
// Bit slice plus its pipeline register. Operands are shifted left so the
// bit under test is always at the top position.
module mmt_stage
  import mmt_pkg::*;
#(
  parameter int unsigned N_OPS = 9,
  parameter int unsigned WIDTH = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  mode_e                       mode_i,
  input  logic [N_OPS-1:0][WIDTH-1:0] ops_i,
  input  logic [N_OPS-1:0]            flags_i,
  input  logic [WIDTH-1:0]            res_i,
  output logic                        valid_o,
  output mode_e                       mode_o,
  output logic [N_OPS-1:0][WIDTH-1:0] ops_o,
  output logic [N_OPS-1:0]            flags_o,
  output logic [WIDTH-1:0]            res_o
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [N_OPS-1:0] cur_bits;
  logic [N_OPS-1:0] next_flags;
  logic             hit;
  logic [N_OPS-1:0][WIDTH-1:0] ops_shift;

  for (genvar i = 0; i < N_OPS; i++) begin : g_col
    assign cur_bits[i]  = ops_i[i][TOP];
    assign ops_shift[i] = {ops_i[i][TOP-1:0], 1'b0};
  end

  mmt_bit_pe #(.N_OPS(N_OPS)) u_pe (
    .bits_i (cur_bits),
    .flags_i(flags_i),
    .hit_o  (hit),
    .flags_o(next_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= MODE_MAX;
      ops_o   <= '0;
      flags_o <= '0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      mode_o  <= mode_i;
      if (valid_i) begin
        ops_o   <= ops_shift;
        flags_o <= next_flags;
        res_o   <= {res_i[TOP-1:0], hit};
      end else begin
        ops_o   <= '0;
        flags_o <= '0;
        res_o   <= '0;
      end
    end
  end
endmodule

// File: rtl/minmax_tracker.sv
`timescale 1ns/1ps
module minmax_tracker
  import mmt_pkg::*;
#(
  parameter int unsigned N_OPS = 9,
  parameter int unsigned WIDTH = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   mode_i,
  input  logic [N_OPS*WIDTH-1:0] ops_i,
  output logic                   valid_o,
  output logic [WIDTH-1:0]       res_o,
  output logic [N_OPS-1:0]       cand_o
);
  localparam int unsigned STAGES = WIDTH;

  logic [N_OPS-1:0][WIDTH-1:0] ops_arr;
  logic [N_OPS-1:0][WIDTH-1:0] ops_cond;

  logic [STAGES:0]                   v_w;
  mode_e                             m_w     [STAGES+1];
  logic [N_OPS-1:0][WIDTH-1:0]       ops_w   [STAGES+1];
  logic [STAGES:0][N_OPS-1:0]        flags_w;
  logic [STAGES:0][WIDTH-1:0]        res_w;
  logic [0:0][WIDTH-1:0]             res_out;
  logic                              out_inv;

  for (genvar i = 0; i < N_OPS; i++) begin : g_unpack
    assign ops_arr[i] = ops_i[i*WIDTH +: WIDTH];
  end

  mmt_cond #(.N_OPS(N_OPS), .WIDTH(WIDTH)) u_in_cond (
    .ops_i   (ops_arr),
    .invert_i(mode_i),
    .ops_o   (ops_cond)
  );

  assign v_w[0]     = valid_i;
  assign m_w[0]     = mode_e'(mode_i);
  assign ops_w[0]   = ops_cond;
  assign flags_w[0] = '1;
  assign res_w[0]   = '0;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    mmt_stage #(.N_OPS(N_OPS), .WIDTH(WIDTH)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(v_w[s]),
      .mode_i (m_w[s]),
      .ops_i  (ops_w[s]),
      .flags_i(flags_w[s]),
      .res_i  (res_w[s]),
      .valid_o(v_w[s+1]),
      .mode_o (m_w[s+1]),
      .ops_o  (ops_w[s+1]),
      .flags_o(flags_w[s+1]),
      .res_o  (res_w[s+1])
    );
  end

  assign out_inv = v_w[STAGES] && (m_w[STAGES] == MODE_MIN);

  mmt_cond #(.N_OPS(1), .WIDTH(WIDTH)) u_out_cond (
    .ops_i   (res_w[STAGES]),
    .invert_i(out_inv),
    .ops_o   (res_out)
  );

  assign valid_o = v_w[STAGES];
  assign res_o   = res_out[0];
  assign cand_o  = flags_w[STAGES];
endmodule

// File: rtl/mmt_checker.sv
`timescale 1ns/1ps
module mmt_checker #(
  parameter int unsigned N_OPS = 9,
  parameter int unsigned WIDTH = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_o,
  input logic [WIDTH-1:0]           res_o,
  input logic [N_OPS-1:0]           cand_o,
  input logic [WIDTH:0]             stage_valid,
  input logic [WIDTH:0][N_OPS-1:0]  stage_flags,
  input logic [WIDTH:0][WIDTH-1:0]  stage_res
);
  for (genvar s = 0; s < WIDTH; s++) begin : g_stage_chk
    // R4
    flags_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stage_valid[s+1] |-> ((stage_flags[s+1] & ~$past(stage_flags[s])) == '0));
    // R4
    flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stage_valid[s+1] && !stage_res[s+1][0]) |-> (stage_flags[s+1] == $past(stage_flags[s])));
  end

  // R4
  cand_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cand_o != '0));

  // R6
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (res_o == '0 && cand_o == '0));
endmodule

bind minmax_tracker mmt_checker #(.N_OPS(N_OPS), .WIDTH(WIDTH)) u_mmt_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_o    (valid_o),
  .res_o      (res_o),
  .cand_o     (cand_o),
  .stage_valid(v_w),
  .stage_flags(flags_w),
  .stage_res  (res_w)
);

// File: tb/test_minmax_tracker.sv
`timescale 1ns/1ps
module test_minmax_tracker;
  localparam int N = 9;
  localparam int W = 8;
  localparam int DEPTH = 1024;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic             mode_i = 1'b0;
  logic [N*W-1:0]   ops_i = '0;
  logic             valid_o;
  logic [W-1:0]     res_o;
  logic [N-1:0]     cand_o;

  int checks = 0;
  int fails  = 0;
  int sent   = 0;
  int rcv    = 0;
  int cyc    = 0;

  logic [W-1:0] exp_res  [DEPTH];
  logic [N-1:0] exp_cand [DEPTH];
  logic         exp_mode [DEPTH];
  int           exp_cyc  [DEPTH];

  always #2 clk = ~clk;

  minmax_tracker #(.N_OPS(N), .WIDTH(W)) i_minmax_tracker (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .valid_i(valid_i),
    .mode_i (mode_i),
    .ops_i  (ops_i),
    .valid_o(valid_o),
    .res_o  (res_o),
    .cand_o (cand_o)
  );

  // Output monitor, samples 1 ns after each rising edge.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (rst_n) begin
      checks++;
      if (valid_o) begin
        if (rcv >= sent) begin
          fails++;
          $display("FAIL R6: unexpected valid_o, res=%0d cand=%b (expected no output)", res_o, cand_o);
        end else begin
          if (res_o !== exp_res[rcv]) begin
            fails++;
            $display("FAIL %s: set %0d res=%0d expected %0d", exp_mode[rcv] ? "R3" : "R2",
                     rcv, res_o, exp_res[rcv]);
          end
          checks++;
          if (cand_o !== exp_cand[rcv]) begin
            fails++;
            $display("FAIL R4: set %0d cand=%b expected %b", rcv, cand_o, exp_cand[rcv]);
          end
          checks++;
          if (cyc != exp_cyc[rcv] + W - 1) begin
            fails++;
            $display("FAIL R1: set %0d out at cycle %0d expected %0d", rcv, cyc,
                     exp_cyc[rcv] + W - 1);
          end
          rcv++;
        end
      end else if (res_o !== '0 || cand_o !== '0) begin
        fails++;
        $display("FAIL R6: idle outputs res=%0d cand=%b expected 0 and 0", res_o, cand_o);
      end
    end
  end

  task automatic send(input logic [N-1:0][W-1:0] v, input logic md);
    logic [W-1:0] best;
    @(negedge clk);
    best = md ? '1 : '0;
    for (int i = 0; i < N; i++)
      if (md ? (v[i] < best) : (v[i] > best)) best = v[i];
    for (int i = 0; i < N; i++) exp_cand[sent][i] = (v[i] == best);
    exp_res[sent]  = best;
    exp_mode[sent] = md;
    exp_cyc[sent]  = cyc + 1;
    sent++;
    valid_i = 1'b1;
    mode_i  = md;
    ops_i   = v;
  endtask

  // R6: junk on data and mode while valid is low.
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
      mode_i  = 1'($urandom);
      for (int i = 0; i < N; i++) ops_i[i*W +: W] = W'($urandom);
    end
  endtask

  task automatic drain(input string tag);
    idle(W + 3);
    checks++;
    if (rcv != sent) begin
      fails++;
      $display("FAIL R1 (%s): received %0d results expected %0d", tag, rcv, sent);
    end
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || res_o !== '0 || cand_o !== '0) begin
      fails++;
      $display("FAIL R7: in reset valid=%b res=%0d cand=%b expected 0 0 0", valid_o, res_o, cand_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reference;
    logic [N-1:0][W-1:0] v;
    v = '0;
    v[0] = 3; v[1] = 5; v[2] = 11; v[3] = 12; v[4] = 8;
    send(v, 1'b0);                       // R2: max 12, only operand 3
    v[5] = 3; v[6] = 5; v[7] = 11; v[8] = 8;
    send(v, 1'b1);                       // R3: min 3, operands 0 and 5 tie
    drain("reference");
  endtask

  task automatic t_random_max;
    logic [N-1:0][W-1:0] v;
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < N; i++) v[i] = W'($urandom);
      send(v, 1'b0);                     // R2, back to back
    end
    drain("random max");
  endtask

  task automatic t_random_min;
    logic [N-1:0][W-1:0] v;
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < N; i++) v[i] = W'($urandom);
      send(v, 1'b1);                     // R3
    end
    drain("random min");
  endtask

  task automatic t_ties;
    logic [N-1:0][W-1:0] v;
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < N; i++) v[i] = W'($urandom_range(0, 3)) << 6;
      send(v, 1'(k));                    // R4 ties in both modes
    end
    drain("ties");
  endtask

  task automatic t_mode_alternate;
    logic [N-1:0][W-1:0] v;
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < N; i++) v[i] = W'($urandom);
      send(v, 1'(k % 2));                // R5: per-set mode
      if (k % 7 == 6) idle(2);           // R6: gaps in the stream
    end
    drain("mode alternate");
  endtask

  task automatic t_uniform;
    logic [N-1:0][W-1:0] v;
    logic [W-1:0] vals [3];
    vals[0] = '0; vals[1] = '1; vals[2] = 8'h5A;
    for (int j = 0; j < 3; j++) begin
      for (int i = 0; i < N; i++) v[i] = vals[j];
      send(v, 1'b0);                     // R8
      send(v, 1'b1);                     // R8
    end
    drain("uniform");
  endtask

  initial begin
    t_reset_state();
    idle(2);
    t_reference();
    t_random_max();
    t_random_min();
    t_ties();
    t_mode_alternate();
    t_uniform();
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected end of test");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule